// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Status Flags

A first-in first-out buffer with a 36-bit data path. Writes and reads run on separate, unrelated clocks. The storage depth `DEPTH` is a power of two. The timing mode is taken from `mode_i` while `rst_ni` is low and stays fixed until the next reset.

Standard mode (`mode_i` = 0) delivers a word only when a read is requested. In this mode the block reports an empty flag and a full flag. Look-ahead mode (`mode_i` = 1) moves the oldest word into an output register without any request. In this mode the block reports an output-ready flag and an input-ready flag, and the output register adds one word of capacity. Both modes report half-full, almost-empty and almost-full flags. Because of the extra word, each threshold in look-ahead mode sits one word higher than in standard mode.

The almost-empty offset `n` and the almost-full offset `m` reset to `OFF_RST`. They can be replaced through a parallel load port only until the first write is accepted.

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_i` is captured while `rst_ni` is low: 0 selects standard mode and 1 selects look-ahead mode. Changing `mode_i` after reset has no effect on the flag polarities or on read behaviour.
- R2: In standard mode, `rd_flag_o` is the empty flag, active low: 0 while no word is stored and 1 once a word is stored. A read (`ren_ni` = 0) on a stored word puts that word on `rdata_o` at the next `rclk_i` edge. A read while empty leaves `rdata_o` unchanged.
- R3: In standard mode, `wr_flag_o` is the full flag, active low: 0 once `DEPTH` words are stored. Writes while full are dropped, and a read raises the flag to 1 again.
- R4: In look-ahead mode, the oldest word appears on `rdata_o` without any read request. `rd_flag_o` is 0 while that word is valid and 1 once no word is left. A read while `rd_flag_o` is 1 is ignored and leaves `rdata_o` unchanged.
- R5: In look-ahead mode the capacity is `DEPTH`+1 words. `wr_flag_o` is 1 when the FIFO is full and 0 otherwise. Writes while full are dropped, and a read returns the flag to 0.
- R6: `pae_no` is 0 while the stored count is at most `n` (standard mode) or at most `n`+1 (look-ahead mode), and 1 above that.
- R7: `hf_no` is 0 while the stored count exceeds `DEPTH`/2 (standard mode) or `DEPTH`/2+1 (look-ahead mode), and 1 otherwise.
- R8: `paf_no` is 0 while the stored count is at least `DEPTH`-`m` (standard mode) or at least `DEPTH`+1-`m` (look-ahead mode), and 1 otherwise.
- R9: On reset, `n` and `m` take the value `OFF_RST`. A `wclk_i` edge with `cfg_ld_i` = 1 loads `ae_off_i` into `n` and `af_off_i` into `m`, but only if no write has been accepted since reset. Once a write has been accepted, loads are ignored.
- R10: Words leave in the order they were written. This holds while writes and reads run at the same time on their two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| mode_i | input | 1 | Mode select, sampled during reset (0 standard, 1 look-ahead) |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | DW | Read data register |
| cfg_ld_i | input | 1 | Offset load strobe (write clock) |
| ae_off_i | input | AW | Almost-empty offset `n` to load |
| af_off_i | input | AW | Almost-full offset `m` to load |
| wr_flag_o | output | 1 | Full flag, active low (standard) / input-ready flag, 1 when full (look-ahead) |
| rd_flag_o | output | 1 | Empty flag, active low (standard) / output-ready flag, 0 when valid (look-ahead) |
| hf_no | output | 1 | Half-full flag, active low |
| pae_no | output | 1 | Programmable almost-empty flag, active low |
| paf_no | output | 1 | Programmable almost-full flag, active low |

## Verification
A write and a read can land in the same stretch of cycles. Each one moves its own pointer while the other clock domain sees that pointer only after synchronization. The bench first places eight words in the FIFO. It then drives a write every write-clock cycle and a read every read-clock cycle at the same time, with the two clocks offset in phase. A queue model checks every word read against the oldest word written. After activity stops and the flags settle, the flags are compared with the model's count.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_LOOK = 1'b1
  } fifo_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr.sv
module dmf_wr
  import dmf_pkg::*;
#(
  parameter int AW      = 10,
  parameter int OFF_RST = 127
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wen_ni,
  input  logic          cfg_ld_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  input  logic [AW:0]   rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic [AW-1:0] ae_off_o,
  output logic          wr_flag_o,
  output logic          hf_no,
  output logic          paf_no
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF_P  = {2'b01, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] OFF_INIT = AW'(OFF_RST);

  fifo_mode_e    mode_q;
  logic [PW-1:0] rq1_q, rq2_q, rbin_sync;
  logic [PW-1:0] wbin_q, wbin_nxt, wgray_q, cnt_nxt;
  logic          full_q, hf_n_q, paf_n_q, open_q, wr_ok;
  logic [AW-1:0] ae_q, af_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_i);
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq1_q <= '0;
      rq2_q <= '0;
    end else begin
      rq1_q <= rgray_i;
      rq2_q <= rq1_q;
    end
  end

  assign rbin_sync = PW'(gray2bin(32'(rq2_q)));
  assign wr_ok     = ~wen_ni & ~full_q;
  assign wbin_nxt  = wbin_q + PW'(wr_ok);
  assign cnt_nxt   = wbin_nxt - rbin_sync;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      hf_n_q  <= 1'b1;
      paf_n_q <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(bin2gray(32'(wbin_nxt)));
      full_q  <= (cnt_nxt == DEPTH_P);
      hf_n_q  <= ~(cnt_nxt > HALF_P);
      paf_n_q <= ~(cnt_nxt >= (DEPTH_P - {1'b0, af_q}));
    end
  end

  // offsets open for loading until the first accepted write
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b1;
      ae_q   <= OFF_INIT;
      af_q   <= OFF_INIT;
    end else begin
      if (wr_ok) open_q <= 1'b0;
      if (cfg_ld_i && open_q) begin
        ae_q <= ae_off_i;
        af_q <= af_off_i;
      end
    end
  end

  assign we_o      = wr_ok;
  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign ae_off_o  = ae_q;
  assign wr_flag_o = (mode_q == MODE_LOOK) ? full_q : ~full_q;
  assign hf_no     = hf_n_q;
  assign paf_no    = paf_n_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_sync) <= DEPTH_P); // R3
  AST_GRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R10
  AST_CFG_LOCK: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !open_q |=> $stable(ae_q) && $stable(af_q)); // R9
  AST_MODE_STABLE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $stable(mode_q)); // R1
endmodule

// File: rtl/dmf_rd.sv
module dmf_rd
  import dmf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ren_ni,
  input  logic [AW:0]   wgray_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          pae_no
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

  fifo_mode_e    mode_q;
  logic [PW-1:0] wq1_q, wq2_q, wbin_sync;
  logic [PW-1:0] rbin_q, rbin_nxt, rgray_q, cnt_nxt;
  logic [DW-1:0] dout_q;
  logic          nonempty_q, pae_q, ov_q, ov_nxt, rd_fire, pop;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_i);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wq1_q <= '0;
      wq2_q <= '0;
    end else begin
      wq1_q <= wgray_i;
      wq2_q <= wq1_q;
    end
  end

  assign wbin_sync = PW'(gray2bin(32'(wq2_q)));

  // look-ahead: refill the output register when it is empty or being consumed
  assign rd_fire  = ~ren_ni & ov_q;
  assign pop      = (mode_q == MODE_LOOK) ? (nonempty_q & (~ov_q | rd_fire))
                                          : (~ren_ni & nonempty_q);
  assign ov_nxt   = (mode_q == MODE_LOOK) & (pop | (ov_q & ~rd_fire));
  assign rbin_nxt = rbin_q + PW'(pop);
  assign cnt_nxt  = wbin_sync - rbin_nxt;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      nonempty_q <= 1'b0;
      pae_q      <= 1'b0;
      ov_q       <= 1'b0;
      dout_q     <= '0;
    end else begin
      rbin_q     <= rbin_nxt;
      rgray_q    <= PW'(bin2gray(32'(rbin_nxt)));
      nonempty_q <= (cnt_nxt != '0);
      pae_q      <= (cnt_nxt > {1'b0, ae_off_i});
      ov_q       <= ov_nxt;
      if (pop) dout_q <= mem_rdata_i;
    end
  end

  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign rdata_o   = dout_q;
  assign rd_flag_o = (mode_q == MODE_LOOK) ? ~ov_q : nonempty_q;
  assign pae_no    = pae_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    pop |-> (wbin_sync != rbin_q)); // R2
  AST_RD_COUNT: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wbin_sync - rbin_q) <= DEPTH_P); // R10
  AST_LOOK_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOOK) && ov_q && ren_ni |=> $stable(dout_q) && ov_q); // R4
  AST_STD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD) && ren_ni |=> $stable(dout_q)); // R2
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW      = 36,
  parameter int DEPTH   = 1024,
  parameter int OFF_RST = 127,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wen_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_ni,
  output logic [DW-1:0] rdata_o,
  input  logic          cfg_ld_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  output logic          wr_flag_o,
  output logic          rd_flag_o,
  output logic          hf_no,
  output logic          pae_no,
  output logic          paf_no
);
  logic          we;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic [AW:0]   wgray, rgray;
  logic [DW-1:0] mem_rdata;

  dmf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dmf_wr #(.AW(AW), .OFF_RST(OFF_RST)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .wen_ni    (wen_ni),
    .cfg_ld_i  (cfg_ld_i),
    .ae_off_i  (ae_off_i),
    .af_off_i  (af_off_i),
    .rgray_i   (rgray),
    .we_o      (we),
    .waddr_o   (waddr),
    .wgray_o   (wgray),
    .ae_off_o  (ae_off),
    .wr_flag_o (wr_flag_o),
    .hf_no     (hf_no),
    .paf_no    (paf_no)
  );

  // ae_off is quasi-static: it only changes before the first write
  dmf_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .ren_ni      (ren_ni),
    .wgray_i     (wgray),
    .ae_off_i    (ae_off),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .rd_flag_o   (rd_flag_o),
    .pae_no      (pae_no)
  );
endmodule

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
  localparam int D  = 16;
  localparam int N0 = 3;
  localparam int AW = $clog2(D);

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0, mode_i = 1'b0;
  logic          wen_ni = 1'b1, ren_ni = 1'b1, cfg_ld_i = 1'b0;
  logic [35:0]   wdata_i = '0;
  logic [AW-1:0] ae_off_i = '0, af_off_i = '0;
  logic [35:0]   rdata_o;
  logic          wr_flag_o, rd_flag_o, hf_no, pae_no, paf_no;

  int total = 0, bad = 0, seq = 0, n_cur = N0, m_cur = N0;
  bit look = 1'b0;
  logic [35:0] q[$];

  always #10 wclk = ~wclk;
  initial begin #7; forever #10 rclk = ~rclk; end

  dual_mode_fifo #(.DW(36), .DEPTH(D), .OFF_RST(N0)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .mode_i(mode_i),
    .wen_ni(wen_ni), .wdata_i(wdata_i), .ren_ni(ren_ni), .rdata_o(rdata_o),
    .cfg_ld_i(cfg_ld_i), .ae_off_i(ae_off_i), .af_off_i(af_off_i),
    .wr_flag_o(wr_flag_o), .rd_flag_o(rd_flag_o), .hf_no(hf_no),
    .pae_no(pae_no), .paf_no(paf_no)
  );

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic chk_flags(string ctx);
    int c = q.size();
    @(negedge rclk);
    if (!look) begin
      chk({ctx, " R2 empty flag"}, 36'(rd_flag_o), 36'(c > 0));
      chk({ctx, " R3 full flag"}, 36'(wr_flag_o), 36'(!(c >= D)));
      chk({ctx, " R7 half"}, 36'(hf_no), 36'(!(c > D/2)));
      chk({ctx, " R6 almost-empty"}, 36'(pae_no), 36'(c > n_cur));
      chk({ctx, " R8 almost-full"}, 36'(paf_no), 36'(!(c >= D - m_cur)));
    end else begin
      chk({ctx, " R4 out-ready"}, 36'(rd_flag_o), 36'(!(c > 0)));
      chk({ctx, " R5 in-ready"}, 36'(wr_flag_o), 36'(c >= D + 1));
      chk({ctx, " R7 half"}, 36'(hf_no), 36'(!(c > D/2 + 1)));
      chk({ctx, " R6 almost-empty"}, 36'(pae_no), 36'(c > n_cur + 1));
      chk({ctx, " R8 almost-full"}, 36'(paf_no), 36'(!(c >= D + 1 - m_cur)));
      if (c > 0) chk({ctx, " R4 head word"}, rdata_o, q[0]);
    end
  endtask

  task automatic do_reset(bit m);
    rst_ni = 1'b0; mode_i = m; wen_ni = 1'b1; ren_ni = 1'b1; cfg_ld_i = 1'b0;
    repeat (3) @(negedge wclk);
    rst_ni = 1'b1;
    q.delete(); look = m; n_cur = N0; m_cur = N0;
    repeat (2) @(negedge wclk);
    mode_i = ~m; // R1: must be ignored
  endtask

  function automatic logic [35:0] next_word();
    seq++;
    return {4'h9, 32'(seq * 32'h0101_0007)};
  endfunction

  task automatic write_one();
    logic [35:0] w = next_word();
    @(negedge wclk);
    wen_ni = 1'b0; wdata_i = w;
    @(negedge wclk);
    wen_ni = 1'b1;
    if (q.size() < (look ? D + 1 : D)) q.push_back(w);
  endtask

  task automatic read_one(string ctx);
    logic [35:0] prev;
    @(negedge rclk);
    if (look && q.size() > 0) chk({ctx, " R4 data before read"}, rdata_o, q[0]);
    prev = rdata_o;
    ren_ni = 1'b0;
    @(negedge rclk);
    ren_ni = 1'b1;
    if (q.size() > 0) begin
      if (!look) chk({ctx, " R2 read data"}, rdata_o, q.pop_front());
      else void'(q.pop_front());
    end else begin
      chk({ctx, " R2/R4 read while empty ignored"}, rdata_o, prev);
    end
  endtask

  task automatic stream_wr(int k);
    for (int i = 0; i < k; i++) begin
      logic [35:0] w = next_word();
      @(negedge wclk);
      wen_ni = 1'b0; wdata_i = w;
      q.push_back(w);
    end
    @(negedge wclk);
    wen_ni = 1'b1;
  endtask

  task automatic stream_rd(int k);
    logic [35:0] exp = '0;
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      if (!look) begin
        if (i > 0) chk("R10 std concurrent order", rdata_o, exp);
        exp = q.pop_front();
      end else begin
        chk("R10 look concurrent order", rdata_o, q[0]);
        void'(q.pop_front());
      end
      ren_ni = 1'b0;
    end
    @(negedge rclk);
    ren_ni = 1'b1;
    if (!look) chk("R10 std concurrent last", rdata_o, exp);
  endtask

  task automatic concurrent(bit m);
    do_reset(m);
    for (int i = 0; i < 8; i++) write_one();
    settle();
    fork
      stream_wr(24);
      stream_rd(24);
    join
    settle();
    chk_flags("R10 after stream");
    while (q.size() > 0) read_one("R10 drain");
    settle();
    chk_flags("R10 drained");
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL R10 watchdog act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // standard mode, default offsets
    do_reset(1'b0);
    settle();
    chk_flags("R1 reset std");
    chk("R2 reset data", rdata_o, 36'h0);
    read_one("R2 empty");
    for (int i = 0; i < D + 2; i++) begin
      write_one(); settle(); chk_flags("R1 std fill");
    end
    for (int i = 0; i < D + 1; i++) begin
      read_one("std drain"); settle(); chk_flags("R3 std drain");
    end

    // look-ahead mode with loaded offsets
    do_reset(1'b1);
    @(negedge wclk);
    cfg_ld_i = 1'b1; ae_off_i = AW'(5); af_off_i = AW'(2);
    @(negedge wclk);
    cfg_ld_i = 1'b0;
    n_cur = 5; m_cur = 2;
    settle();
    chk_flags("R9 look reset");
    write_one(); settle(); chk_flags("R4 first word no read");
    @(negedge wclk);
    cfg_ld_i = 1'b1; ae_off_i = AW'(1); af_off_i = AW'(1);
    @(negedge wclk);
    cfg_ld_i = 1'b0;
    for (int i = 0; i < D + 1; i++) begin
      write_one(); settle(); chk_flags("R9 R5 look fill");
    end
    for (int i = 0; i < D + 2; i++) begin
      read_one("R4 look drain"); settle(); chk_flags("R5 look drain");
    end

    concurrent(1'b0);
    concurrent(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule